// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block is the bridge between a byte-addressable I/O port bus and a configuration space that is reached one dword at a time. Software first writes a 32-bit configuration address to the address port. It then reads or writes the four data ports that follow it. The address selects a target by bus/device/function and a dword register by offset. Its top bit gates every data-port access.

Each data-port access is 1, 2 or 4 bytes wide and may start at any of the four data-port bytes. The bridge turns it into one dword-aligned downstream transaction, which carries a byte-enable mask and write data moved onto the matching byte lanes. Read data coming back is shifted down to byte lane 0 of the port. When the target reports that no function exists, the read returns all ones. While the gate bit is clear, no transaction is issued at all.

The upstream side is a request held by the host until the bridge pulses `io_ready`. The downstream side is a valid/ready handshake. Its completion also carries a hit flag and the read dword.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset `io_ready` and `cfg_req_valid` are low and the configuration address reads back as zero.
- R2: A write to port 0xCF8 stores all 32 bits of `io_wdata`. A read of port 0xCF8 returns the stored value with bits 30:24 and 1:0 forced to zero. Either access completes one cycle after it is presented.
- R3: A data-port access (ports 0xCFC to 0xCFF) while address bit 31 is set issues exactly one downstream transaction. In it, `cfg_req_bdf` = address bits 23:8, `cfg_req_offset` = address bits 7:2, and `cfg_req_dev` = bits 15:11 of that bdf field.
- R4: For a write at port 0xCFC+k with size s bytes, the data is shifted left by 8*k bits and `cfg_req_be` bit i is set for k <= i < k+s. Bytes shifted beyond bit 31 or lane 3 are discarded, and the mask is never zero for legal sizes.
- R5: For a read at port 0xCFC+k that hits, `io_rdata` equals the returned dword shifted right by 8*k bits, with zeros filled in from the top.
- R6: A read whose downstream completion has `cfg_rsp_hit` low returns 0xFFFFFFFF.
- R7: With address bit 31 clear, a data-port access issues no downstream transaction. A read returns 0xFFFFFFFF and a write leaves the target unchanged.
- R8: `io_ready` stays low while a downstream transaction waits for `cfg_req_ready` and rises for exactly one cycle, in the cycle after the transaction is accepted. The request fields are held stable while waiting.
- R9: An access to any other port completes after one cycle with read data 0xFFFFFFFF. It issues no transaction and leaves the address register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | Upstream access request, held until io_ready |
| io_write | input | 1 | 1 = port write, 0 = port read |
| io_port | input | 16 | I/O port address |
| io_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| io_wdata | input | 32 | Port write data, byte 0 in bits 7:0 |
| io_ready | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Port read data, valid with io_ready |
| cfg_req_valid | output | 1 | Downstream transaction valid |
| cfg_req_ready | input | 1 | Downstream completion / acceptance |
| cfg_req_write | output | 1 | Transaction is a write |
| cfg_req_bdf | output | 16 | Target bus/device/function |
| cfg_req_dev | output | 5 | Device number part of the target |
| cfg_req_offset | output | 6 | Dword register index |
| cfg_req_wdata | output | 32 | Lane-aligned write data |
| cfg_req_be | output | 4 | Byte-enable mask |
| cfg_rsp_hit | input | 1 | Function present at the target |
| cfg_rsp_rdata | input | 32 | Read dword from the target |

## Verification
The hardest case to reach is a partial access near the top of the dword: a 2-byte write at the last data port, whose mask and data must both be cut off at lane 3. The bench reaches it by first writing a known full dword into the bench's target model. It then issues byte and word writes at the upper ports and reads the dword back at every lane offset. Every merged value is predicted from the mask rule. Back-pressure is reached by giving the target model a programmable wait count and timing the completion pulse against it.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

  localparam int DW      = 32;
  localparam int NBYTES  = DW / 8;
  localparam int LANE_W  = $clog2(NBYTES);
  localparam int SIZE_W  = LANE_W + 1;
  localparam int BDF_W   = 16;
  localparam int OFF_W   = 6;
  localparam int DEV_W   = 5;
  localparam int DEV_LSB = 11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DONE = 2'd2
  } txn_state_e;

  typedef enum logic [1:0] {
    PK_OTHER = 2'd0,
    PK_ADDR  = 2'd1,
    PK_DATA  = 2'd2
  } port_kind_e;

  typedef struct packed {
    logic              write;
    logic [BDF_W-1:0]  bdf;
    logic [OFF_W-1:0]  offset;
    logic [DW-1:0]     wdata;
    logic [NBYTES-1:0] be;
    logic [LANE_W-1:0] lane;
  } cfg_req_t;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_bridge_pkg::*;
#(
  parameter logic [DW-1:0] RB_CLEAR = 32'h7F00_0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  output logic             enabled,
  output logic [BDF_W-1:0] bdf,
  output logic [OFF_W-1:0] offset,
  output logic [DW-1:0]    readback
);

  logic [DW-1:0] addr_q;
  logic [DW-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (wr_en) addr_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_en) addr_q <= addr_d;
  end

  assign enabled  = addr_q[DW-1];
  assign bdf      = addr_q[8 +: BDF_W];
  assign offset   = addr_q[2 +: OFF_W];
  assign readback = addr_q & ~RB_CLEAR;

endmodule

// File: rtl/cfg_lane_align.sv
module cfg_lane_align
  import cfg_bridge_pkg::*;
(
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [DW-1:0]     wr_data,
  input  logic [LANE_W-1:0] rd_lane,
  input  logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     wr_data_aligned,
  output logic [NBYTES-1:0] wr_be,
  output logic [DW-1:0]     rd_data_aligned
);

  localparam int SUM_W = SIZE_W + 1;

  logic [SUM_W-1:0] lo_idx;
  logic [SUM_W-1:0] hi_idx;

  assign lo_idx = SUM_W'(wr_lane);
  assign hi_idx = lo_idx + SUM_W'(wr_size);

  for (genvar g = 0; g < NBYTES; g++) begin : g_be
    localparam logic [SUM_W-1:0] IDX = SUM_W'(g);
    assign wr_be[g] = (IDX >= lo_idx) && (IDX < hi_idx);
  end

  assign wr_data_aligned = wr_data << {wr_lane, 3'b000};
  assign rd_data_aligned = rd_data >> {rd_lane, 3'b000};

endmodule

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl
  import cfg_bridge_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  input  logic          up_write,
  input  port_kind_e    up_kind,
  input  logic          cfg_enabled,
  input  logic [DW-1:0] addr_readback,
  input  logic          dn_ready,
  input  logic          dn_hit,
  input  logic          dn_write,
  input  logic [DW-1:0] dn_rdata_aligned,
  output logic          up_ready,
  output logic [DW-1:0] up_rdata,
  output logic          dn_valid,
  output logic          addr_wr_en,
  output logic          req_load
);

  localparam logic [DW-1:0] ALL_ONES = '1;

  txn_state_e    state_q, state_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rdata_en;

  always_comb begin
    state_d    = state_q;
    rdata_d    = rdata_q;
    rdata_en   = 1'b0;
    addr_wr_en = 1'b0;
    req_load   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (up_valid) begin
          case (up_kind)
            PK_ADDR: begin
              addr_wr_en = up_write;
              rdata_d    = up_write ? ALL_ONES : addr_readback;
              rdata_en   = 1'b1;
              state_d    = ST_DONE;
            end
            PK_DATA: begin
              if (cfg_enabled) begin
                req_load = 1'b1;
                state_d  = ST_REQ;
              end else begin
                rdata_d  = ALL_ONES;
                rdata_en = 1'b1;
                state_d  = ST_DONE;
              end
            end
            default: begin
              rdata_d  = ALL_ONES;
              rdata_en = 1'b1;
              state_d  = ST_DONE;
            end
          endcase
        end
      end
      ST_REQ: begin
        if (dn_ready) begin
          rdata_d  = (dn_hit && !dn_write) ? dn_rdata_aligned : ALL_ONES;
          rdata_en = 1'b1;
          state_d  = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign up_ready = (state_q == ST_DONE);
  assign dn_valid = (state_q == ST_REQ);
  assign up_rdata = rdata_q;

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfg_bridge_pkg::*;
#(
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [15:0]       io_port,
  input  logic [SIZE_W-1:0] io_size,
  input  logic [DW-1:0]     io_wdata,
  output logic              io_ready,
  output logic [DW-1:0]     io_rdata,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_req_write,
  output logic [BDF_W-1:0]  cfg_req_bdf,
  output logic [DEV_W-1:0]  cfg_req_dev,
  output logic [OFF_W-1:0]  cfg_req_offset,
  output logic [DW-1:0]     cfg_req_wdata,
  output logic [NBYTES-1:0] cfg_req_be,
  input  logic              cfg_rsp_hit,
  input  logic [DW-1:0]     cfg_rsp_rdata
);

  logic              rst_n_int;
  logic              addr_wr_en;
  logic              cfg_enabled;
  logic [BDF_W-1:0]  addr_bdf;
  logic [OFF_W-1:0]  addr_off;
  logic [DW-1:0]     addr_rb;
  logic [DW-1:0]     wdata_al;
  logic [NBYTES-1:0] be_al;
  logic [DW-1:0]     rdata_al;
  logic              req_load;
  port_kind_e        kind;
  cfg_req_t          req_q, req_d;

  cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  always_comb begin
    if (io_port == ADDR_PORT)
      kind = PK_ADDR;
    else if (io_port[15:LANE_W] == DATA_PORT[15:LANE_W])
      kind = PK_DATA;
    else
      kind = PK_OTHER;
  end

  cfg_addr_reg u_addr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (addr_wr_en),
    .wdata    (io_wdata),
    .enabled  (cfg_enabled),
    .bdf      (addr_bdf),
    .offset   (addr_off),
    .readback (addr_rb)
  );

  cfg_lane_align u_align (
    .wr_lane         (io_port[LANE_W-1:0]),
    .wr_size         (io_size),
    .wr_data         (io_wdata),
    .rd_lane         (req_q.lane),
    .rd_data         (cfg_rsp_rdata),
    .wr_data_aligned (wdata_al),
    .wr_be           (be_al),
    .rd_data_aligned (rdata_al)
  );

  always_comb begin
    req_d = req_q;
    if (req_load) begin
      req_d.write  = io_write;
      req_d.bdf    = addr_bdf;
      req_d.offset = addr_off;
      req_d.wdata  = io_write ? wdata_al : '0;
      req_d.be     = be_al;
      req_d.lane   = io_port[LANE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)    req_q <= '0;
    else if (req_load) req_q <= req_d;
  end

  cfg_txn_ctrl u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n_int),
    .up_valid         (io_valid),
    .up_write         (io_write),
    .up_kind          (kind),
    .cfg_enabled      (cfg_enabled),
    .addr_readback    (addr_rb),
    .dn_ready         (cfg_req_ready),
    .dn_hit           (cfg_rsp_hit),
    .dn_write         (req_q.write),
    .dn_rdata_aligned (rdata_al),
    .up_ready         (io_ready),
    .up_rdata         (io_rdata),
    .dn_valid         (cfg_req_valid),
    .addr_wr_en       (addr_wr_en),
    .req_load         (req_load)
  );

  assign cfg_req_write  = req_q.write;
  assign cfg_req_bdf    = req_q.bdf;
  assign cfg_req_dev    = req_q.bdf[DEV_LSB +: DEV_W];
  assign cfg_req_offset = req_q.offset;
  assign cfg_req_wdata  = req_q.wdata;
  assign cfg_req_be     = req_q.be;

endmodule

// File: rtl/cfg_port_bridge_chk.sv
module cfg_port_bridge_chk
  import cfg_bridge_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              io_ready,
  input logic [DW-1:0]     io_rdata,
  input logic              cfg_req_valid,
  input logic              cfg_req_ready,
  input logic              cfg_req_write,
  input logic [BDF_W-1:0]  cfg_req_bdf,
  input logic [DW-1:0]     cfg_req_wdata,
  input logic [NBYTES-1:0] cfg_req_be,
  input logic              cfg_rsp_hit
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_req_be) && $stable(cfg_req_wdata) && $stable(cfg_req_bdf)); // R8

  AST_NO_READY_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> !io_ready); // R8

  AST_READY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && cfg_req_ready |=> io_ready && !cfg_req_valid); // R8

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    io_ready |=> !io_ready); // R8

  AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> cfg_req_be != '0); // R4

  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && cfg_req_ready && !cfg_rsp_hit && !cfg_req_write |=> io_rdata == '1); // R6

endmodule

bind cfg_port_bridge cfg_port_bridge_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .io_ready      (io_ready),
  .io_rdata      (io_rdata),
  .cfg_req_valid (cfg_req_valid),
  .cfg_req_ready (cfg_req_ready),
  .cfg_req_write (cfg_req_write),
  .cfg_req_bdf   (cfg_req_bdf),
  .cfg_req_wdata (cfg_req_wdata),
  .cfg_req_be    (cfg_req_be),
  .cfg_rsp_hit   (cfg_rsp_hit)
);

// File: tb/cfg_port_bridge_tb_top.sv
`timescale 1ns/1ps
module cfg_port_bridge_tb_top;

  logic        clk;
  logic        rst_n;
  logic        io_valid, io_write;
  logic [15:0] io_port;
  logic [2:0]  io_size;
  logic [31:0] io_wdata;
  logic        io_ready;
  logic [31:0] io_rdata;
  logic        cfg_req_valid, cfg_req_ready, cfg_req_write;
  logic [15:0] cfg_req_bdf;
  logic [4:0]  cfg_req_dev;
  logic [5:0]  cfg_req_offset;
  logic [31:0] cfg_req_wdata;
  logic [3:0]  cfg_req_be;
  logic        cfg_rsp_hit;
  logic [31:0] cfg_rsp_rdata;

  int checks = 0;
  int errors = 0;

  localparam logic [15:0] PRESENT_BDF = 16'h0800;
  logic [31:0] tmem [64];
  int          latency = 0;
  int          wcnt = 0;
  int          nreq = 0;
  logic [15:0] last_bdf;
  logic [4:0]  last_dev;
  logic [5:0]  last_off;
  logic [31:0] last_wdata;
  logic [3:0]  last_be;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  cfg_port_bridge dut_i (.*);

  always @(negedge clk) begin
    if (cfg_req_valid && !cfg_req_ready) begin
      if (wcnt >= latency) begin
        cfg_req_ready = 1'b1;
        cfg_rsp_hit   = (cfg_req_bdf == PRESENT_BDF);
        cfg_rsp_rdata = cfg_rsp_hit ? tmem[cfg_req_offset] : 32'hDEAD_BEEF;
        last_bdf = cfg_req_bdf; last_dev = cfg_req_dev; last_off = cfg_req_offset;
        last_wdata = cfg_req_wdata; last_be = cfg_req_be;
        if (cfg_req_write && cfg_rsp_hit)
          for (int b = 0; b < 4; b++)
            if (cfg_req_be[b]) tmem[cfg_req_offset][b*8 +: 8] = cfg_req_wdata[b*8 +: 8];
        nreq++;
        wcnt = 0;
      end else wcnt++;
    end else begin
      cfg_req_ready = 1'b0;
    end
  end

  task automatic check32(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic io_access(input logic wr, input logic [15:0] port, input logic [2:0] sz,
                           input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_port = port; io_size = sz; io_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!io_ready && cyc < 1000);
    rd = io_rdata;
    io_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; int cyc;
    check32("R1", "io_ready after reset", {31'b0, io_ready}, 32'h0);
    check32("R1", "req_valid after reset", {31'b0, cfg_req_valid}, 32'h0);
    io_access(1'b0, 16'h0CF8, 3'd4, 32'h0, rd, cyc);
    check32("R1", "address readback", rd, 32'h0);
  endtask

  task automatic t_addr_port();
    logic [31:0] rd; int cyc;
    io_access(1'b1, 16'h0CF8, 3'd4, 32'hFFFF_FFFF, rd, cyc);
    check32("R2", "address write latency", cyc, 1);
    io_access(1'b0, 16'h0CF8, 3'd4, 32'h0, rd, cyc);
    check32("R2", "masked readback", rd, 32'h80FF_FFFC);
  endtask

  task automatic t_full_write();
    logic [31:0] rd; int cyc; int n0;
    io_access(1'b1, 16'h0CF8, 3'd4, 32'h8008_0010, rd, cyc);
    n0 = nreq;
    io_access(1'b1, 16'h0CFC, 3'd4, 32'hAABB_CCDD, rd, cyc);
    check32("R3", "one request", nreq - n0, 1);
    check32("R3", "bdf", {16'h0, last_bdf}, 32'h0800);
    check32("R3", "offset", {26'h0, last_off}, 32'd4);
    check32("R3", "device number", {27'h0, last_dev}, 32'd1);
    check32("R4", "dword be", {28'h0, last_be}, 32'hF);
    check32("R4", "dword target", tmem[4], 32'hAABB_CCDD);
  endtask

  task automatic t_partial_write();
    logic [31:0] rd; int cyc;
    io_access(1'b1, 16'h0CFE, 3'd1, 32'h0000_005A, rd, cyc);
    check32("R4", "byte lane2 be", {28'h0, last_be}, 32'h4);
    check32("R4", "byte lane2 data", last_wdata, 32'h005A_0000);
    check32("R4", "byte merge", tmem[4], 32'hAA5A_CCDD);
    io_access(1'b1, 16'h0CFF, 3'd2, 32'h0000_1234, rd, cyc);
    check32("R4", "word at lane3 be truncated", {28'h0, last_be}, 32'h8);
    check32("R4", "word at lane3 data truncated", last_wdata, 32'h3400_0000);
    check32("R4", "word merge", tmem[4], 32'h345A_CCDD);
  endtask

  task automatic t_reads();
    logic [31:0] rd; int cyc;
    io_access(1'b0, 16'h0CFC, 3'd4, 32'h0, rd, cyc);
    check32("R5", "read lane0", rd, 32'h345A_CCDD);
    io_access(1'b0, 16'h0CFD, 3'd2, 32'h0, rd, cyc);
    check32("R5", "read lane1", rd, 32'h0034_5ACC);
    io_access(1'b0, 16'h0CFF, 3'd1, 32'h0, rd, cyc);
    check32("R5", "read lane3", rd, 32'h0000_0034);
  endtask

  task automatic t_miss();
    logic [31:0] rd; int cyc; int n0;
    io_access(1'b1, 16'h0CF8, 3'd4, 32'h8010_0010, rd, cyc);
    n0 = nreq;
    io_access(1'b0, 16'h0CFE, 3'd1, 32'h0, rd, cyc);
    check32("R6", "miss request issued", nreq - n0, 1);
    check32("R6", "miss read all ones", rd, 32'hFFFF_FFFF);
  endtask

  task automatic t_disabled();
    logic [31:0] rd; int cyc; int n0;
    io_access(1'b1, 16'h0CF8, 3'd4, 32'h0008_0010, rd, cyc);
    n0 = nreq;
    io_access(1'b0, 16'h0CFC, 3'd4, 32'h0, rd, cyc);
    check32("R7", "disabled read all ones", rd, 32'hFFFF_FFFF);
    io_access(1'b1, 16'h0CFC, 3'd4, 32'h1111_1111, rd, cyc);
    check32("R7", "no request when disabled", nreq - n0, 0);
    io_access(1'b1, 16'h0CF8, 3'd4, 32'h8008_0010, rd, cyc);
    io_access(1'b0, 16'h0CFC, 3'd4, 32'h0, rd, cyc);
    check32("R7", "target unchanged", rd, 32'h345A_CCDD);
  endtask

  task automatic t_backpressure();
    logic [31:0] rd; int cyc;
    latency = 5;
    io_access(1'b0, 16'h0CFC, 3'd4, 32'h0, rd, cyc);
    check32("R8", "completion waits for target", cyc, 7);
    check32("R8", "data after wait", rd, 32'h345A_CCDD);
    latency = 0;
    io_access(1'b0, 16'h0CFC, 3'd4, 32'h0, rd, cyc);
    check32("R8", "completion no wait", cyc, 2);
  endtask

  task automatic t_other_port();
    logic [31:0] rd; int cyc; int n0;
    n0 = nreq;
    io_access(1'b1, 16'h0CF9, 3'd1, 32'h0000_0000, rd, cyc);
    io_access(1'b0, 16'h0080, 3'd1, 32'h0, rd, cyc);
    check32("R9", "other port latency", cyc, 1);
    check32("R9", "other port data", rd, 32'hFFFF_FFFF);
    check32("R9", "other port no request", nreq - n0, 0);
    io_access(1'b0, 16'h0CF8, 3'd4, 32'h0, rd, cyc);
    check32("R9", "address untouched", rd, 32'h8008_0010);
  endtask

  initial begin
    rst_n = 1'b0; io_valid = 1'b0; io_write = 1'b0; io_port = '0; io_size = 3'd4; io_wdata = '0;
    cfg_req_ready = 1'b0; cfg_rsp_hit = 1'b0; cfg_rsp_rdata = '0;
    for (int i = 0; i < 64; i++) tmem[i] = 32'(i) * 32'h0101_0101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_addr_port();
    t_full_write();
    t_partial_write();
    t_reads();
    t_miss();
    t_disabled();
    t_backpressure();
    t_other_port();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule